// File: doc/BRIEF.md
# Switch-Mapped Memory Bus Decoder

This block is the bus-side control for an 8 KB byte-wide static memory slot on a 16-bit address bus. A 3-bit base-select input, set like a bank of switches, places the slot in one of eight aligned 8 KB windows. The three top address bits are compared with that setting. On a match, the next three address bits pick one of eight 1K rows, and the block raises that row's chip select.

Writes reach the selected row only while the write-allow input is high. Clearing it turns the slot read-only, and reads carry on as usual. The read-data drivers are enabled only for an in-window read. They can also be held off by an active-low external line, so that another board can overlay the slot, for example with a bootstrap loader. That line is honoured only when a configuration input, sampled on each clock, enables the option. The block never requests wait states. The row arrays live outside the block; the testbench models them as eight 1K x 8 banks.

Top module: `swmap_mem_decoder`

## Requirements
- R1: The slot hits when `bus_addr[15:13]` equals `base_sel`, with `base_sel[2]` matched against A15. On a miss, `row_cs`, `row_we` and `bus_data_oe` are all 0.
- R2: On a hit with `mem_rd` or `mem_wr` high, `row_cs` is one-hot with bit number `bus_addr[12:10]` set. With neither strobe high, `row_cs` is all zero.
- R3: `row_we` carries the same one-hot value as `row_cs` only when the slot hits, `mem_wr` is 1 and `wr_allow` is 1. In every other case `row_we` is zero.
- R4: While `wr_allow` is 0, no write alters stored contents. Reads of the slot still assert `row_cs` and `bus_data_oe` and return the earlier data.
- R5: `bus_data_oe` is 1 exactly for a hit with `mem_rd` high and no read disable in effect. `bus_data_out` then equals `rd_data_in`, and is zero otherwise. The read disable has no effect on writes.
- R6: `rdis_opt` is captured into an option register on each rising clock edge and takes effect from the next cycle. While the register holds 0, `ext_rdis_n` is ignored. While it holds 1, `ext_rdis_n` = 0 keeps `bus_data_oe` at 0.
- R7: `ready` is 1 in every cycle (zero wait states).
- R8: `row_addr` equals `bus_addr[9:0]`.
- R9: Reset clears the option register, so `ext_rdis_n` has no effect while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the option register |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| base_sel | input | 3 | Window select, bit 2 matched to A15 |
| mem_rd | input | 1 | Memory read cycle |
| mem_wr | input | 1 | Memory write strobe |
| wr_allow | input | 1 | 1 = writes permitted, 0 = slot read-only |
| rdis_opt | input | 1 | Static enable for the external read disable |
| ext_rdis_n | input | 1 | Active-low external read-driver disable |
| rd_data_in | input | 8 | Data from the selected row array |
| row_cs | output | 8 | One-hot row chip selects |
| row_we | output | 8 | One-hot row write strobes |
| row_addr | output | 10 | Address within a row |
| bus_data_out | output | 8 | Read data toward the bus |
| bus_data_oe | output | 1 | Read-data driver enable (0 = high impedance) |
| ready | output | 1 | Ready, never withdrawn |

## Verification
The read-disable path and the write-strobe path both act on the selected row, and they can fall in the same cycle. To provoke this, the bench holds `ext_rdis_n` low with the option register set and then issues a write to the slot. The write strobe must still fire, and the stored byte must show up once the disable is released. The bench also changes `rdis_opt` just before a clock edge while a read is held steady. The driver enable must keep its old value until that edge and follow the new setting afterwards.

// File: rtl/swmap_pkg.sv
package swmap_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_BOTH  = 2'd3
  } cycle_kind_t;

  function automatic cycle_kind_t decode_cycle(input logic rd, input logic wr);
    return cycle_kind_t'({wr, rd});
  endfunction

  function automatic logic kind_reads(input cycle_kind_t k);
    return (k == CYC_READ) || (k == CYC_BOTH);
  endfunction

  function automatic logic kind_writes(input cycle_kind_t k);
    return (k == CYC_WRITE) || (k == CYC_BOTH);
  endfunction

endpackage

// File: rtl/swmap_window_match.sv
module swmap_window_match #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);

  // The high address field must equal the switch setting bit for bit.
  function automatic logic field_equal(input logic [SEL_W-1:0] a,
                                       input logic [SEL_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  assign hit = field_equal(addr[ADDR_W-1 -: SEL_W], sel);

endmodule

// File: rtl/swmap_row_decode.sv
module swmap_row_decode #(
  parameter int IDX_W = 3,
  localparam int ROWS = 1 << IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [ROWS-1:0]  onehot
);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign onehot[i] = en && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/swmap_read_gate.sv
module swmap_read_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_in,
  input  logic              ext_dis_n,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              oe,
  output logic              opt_state,
  output logic              rd_block
);

  logic opt_q;

  // The option is static configuration, captured once per clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= 1'b0;
    else        opt_q <= opt_in;
  end

  function automatic logic block_reads(input logic opt, input logic line_n);
    return opt && !line_n;
  endfunction

  assign opt_state = opt_q;
  assign rd_block  = block_reads(opt_q, ext_dis_n);
  assign oe        = rd_hit && !rd_block;
  assign data_out  = oe ? data_in : '0;

endmodule

// File: rtl/swmap_mem_decoder.sv
module swmap_mem_decoder #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3,
  parameter int ROW_AW = 10,
  parameter int DATA_W = 8,
  localparam int IDX_W = ADDR_W - SEL_W - ROW_AW,
  localparam int ROWS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              wr_allow,
  input  logic              rdis_opt,
  input  logic              ext_rdis_n,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic [ROWS-1:0]   row_cs,
  output logic [ROWS-1:0]   row_we,
  output logic [ROW_AW-1:0] row_addr,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic              ready
);

  import swmap_pkg::*;

  // Named internal events, observed by the bound checker.
  cycle_kind_t      cyc;
  logic             win_hit;
  logic             access_hit;
  logic             wr_pass;
  logic             rd_hit;
  logic             opt_state;
  logic             rd_block;
  logic [IDX_W-1:0] row_idx;

  assign cyc        = decode_cycle(mem_rd, mem_wr);
  assign row_idx    = bus_addr[ROW_AW +: IDX_W];
  assign access_hit = win_hit && (cyc != CYC_IDLE);
  assign wr_pass    = win_hit && kind_writes(cyc) && wr_allow;
  assign rd_hit     = win_hit && kind_reads(cyc);

  swmap_window_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) win_i (
    .addr (bus_addr),
    .sel  (base_sel),
    .hit  (win_hit)
  );

  swmap_row_decode #(.IDX_W(IDX_W)) cs_dec_i (
    .en     (access_hit),
    .idx    (row_idx),
    .onehot (row_cs)
  );

  swmap_row_decode #(.IDX_W(IDX_W)) we_dec_i (
    .en     (wr_pass),
    .idx    (row_idx),
    .onehot (row_we)
  );

  swmap_read_gate #(.DATA_W(DATA_W)) rd_gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opt_in    (rdis_opt),
    .ext_dis_n (ext_rdis_n),
    .rd_hit    (rd_hit),
    .data_in   (rd_data_in),
    .data_out  (bus_data_out),
    .oe        (bus_data_oe),
    .opt_state (opt_state),
    .rd_block  (rd_block)
  );

  assign row_addr = bus_addr[ROW_AW-1:0];
  assign ready    = 1'b1;

endmodule

// File: rtl/swmap_mem_decoder_chk.sv
module swmap_mem_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3,
  parameter int ROW_AW = 10,
  parameter int DATA_W = 8,
  localparam int IDX_W = ADDR_W - SEL_W - ROW_AW,
  localparam int ROWS  = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SEL_W-1:0]  base_sel,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              wr_allow,
  input logic              rdis_opt,
  input logic [ROWS-1:0]   row_cs,
  input logic [ROWS-1:0]   row_we,
  input logic [DATA_W-1:0] bus_data_out,
  input logic              bus_data_oe,
  input logic              opt_state,
  input logic              rd_block
);

  assert_cs_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_cs) |-> (bus_addr[ADDR_W-1 -: SEL_W] == base_sel));

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_cs));

  assert_cs_row_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_cs) |-> row_cs[bus_addr[ROW_AW +: IDX_W]]);

  assert_we_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_we) |-> (mem_wr && wr_allow && ((row_we & ~row_cs) == '0)));

  assert_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |-> (row_we == '0));

  assert_drv_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (mem_rd && (|row_cs) && !rd_block));

  assert_quiet_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_data_oe |-> (bus_data_out == '0));

  assert_ext_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_state && mem_rd && (|row_cs)) |-> bus_data_oe);

  assert_opt_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (opt_state == $past(rdis_opt)));

endmodule

bind swmap_mem_decoder swmap_mem_decoder_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .ROW_AW(ROW_AW), .DATA_W(DATA_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .base_sel     (base_sel),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .wr_allow     (wr_allow),
  .rdis_opt     (rdis_opt),
  .row_cs       (row_cs),
  .row_we       (row_we),
  .bus_data_out (bus_data_out),
  .bus_data_oe  (bus_data_oe),
  .opt_state    (opt_state),
  .rd_block     (rd_block)
);

// File: tb/swmap_mem_decoder_tb_top.sv
module swmap_mem_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [2:0]  sel = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        allow = 1'b1;
  logic        opt = 1'b0;
  logic        extn = 1'b1;
  logic [7:0]  rdin;
  logic [7:0]  row_cs, row_we;
  logic [9:0]  row_addr;
  logic [7:0]  dout;
  logic        doe, ready;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [7:0] bank [8][1024];
  logic [7:0] shadow [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  swmap_mem_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .base_sel(sel),
    .mem_rd(rd), .mem_wr(wr), .wr_allow(allow), .rdis_opt(opt),
    .ext_rdis_n(extn), .rd_data_in(rdin), .row_cs(row_cs), .row_we(row_we),
    .row_addr(row_addr), .bus_data_out(dout), .bus_data_oe(doe), .ready(ready)
  );

  // Row arrays answer whichever chip select is raised.
  always_comb begin
    rdin = 8'h00;
    for (int i = 0; i < 8; i++)
      if (row_cs[i]) rdin = bank[i][row_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stored(input logic [15:0] a);
    int key = int'(a[12:0]);
    return shadow.exists(key) ? shadow[key] : 8'h00;
  endfunction

  function automatic logic [7:0] row_bit(input logic [15:0] a);
    return 8'(1) << a[12:10];
  endfunction

  task automatic drive(input logic [15:0] a, input logic r, input logic w);
    @(negedge clk);
    addr = a; rd = r; wr = w;
    #1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    logic hit;
    logic [7:0] exp_we;
    drive(a, 1'b0, 1'b1);
    hit = (a[15:13] == sel);
    exp_we = (hit && allow) ? row_bit(a) : 8'h00;
    chk({tag, " R3 row_we"}, 32'(row_we), 32'(exp_we));
    chk({tag, " R7 ready"}, 32'(ready), 32'd1);
    for (int i = 0; i < 8; i++)
      if (row_we[i]) bank[i][row_addr] = d;
    if (hit && allow) shadow[int'(a[12:0])] = d;
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input logic exp_oe, input string tag);
    logic hit;
    drive(a, 1'b1, 1'b0);
    hit = (a[15:13] == sel);
    chk({tag, " R1/R2 row_cs"}, 32'(row_cs), 32'(hit ? row_bit(a) : 8'h00));
    chk({tag, " R5 oe"}, 32'(doe), 32'(exp_oe));
    chk({tag, " R5 data"}, 32'(dout), 32'(exp_oe ? stored(a) : 8'h00));
    chk({tag, " R7 ready"}, 32'(ready), 32'd1);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    opt = 1'b1; extn = 1'b0; sel = 3'd0;
    drive(16'h0000, 1'b1, 1'b0);
    chk("R9 opt cleared in reset, oe", 32'(doe), 32'd1);
    chk("R7 ready in reset", 32'(ready), 32'd1);
    rd = 1'b0; opt = 1'b0; extn = 1'b1;
    #1;
    chk("R2 idle row_cs", 32'(row_cs), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_window();
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      for (int t = 0; t < 8; t++) begin
        drive({3'(t), 13'h00A5}, 1'b1, 1'b0);
        chk($sformatf("R1 hit s=%0d t=%0d", s, t), 32'(|row_cs), 32'(s == t));
        chk($sformatf("R1 miss oe s=%0d t=%0d", s, t), 32'(doe), 32'(s == t));
        rd = 1'b0;
      end
    end
  endtask

  task automatic t_rows();
    sel = 3'd3;
    for (int r = 0; r < 8; r++) begin
      drive({3'd3, 3'(r), 10'h155}, 1'b1, 1'b0);
      chk($sformatf("R2 row %0d", r), 32'(row_cs), 32'(8'(1) << r));
      chk($sformatf("R8 row_addr %0d", r), 32'(row_addr), 32'h155);
      rd = 1'b0;
    end
    drive(16'h6000, 1'b0, 1'b0);
    chk("R2 no strobe", 32'(row_cs), 32'd0);
  endtask

  task automatic t_write_read();
    sel = 3'd5; allow = 1'b1;
    do_write(16'hA000, 8'h3C, "wr low edge");
    do_write(16'hBFFF, 8'hC3, "wr high edge");
    do_write(16'hA7FE, 8'h5A, "wr row1");
    do_write(16'hB2A1, 8'h81, "wr row4");
    do_write(16'h8000, 8'hEE, "R1 wr miss");
    do_read(16'hA000, 1'b1, "rd low edge");
    do_read(16'hBFFF, 1'b1, "rd high edge");
    do_read(16'hA7FE, 1'b1, "rd row1");
    do_read(16'hB2A1, 1'b1, "rd row4");
    do_read(16'h8000, 1'b0, "R1 rd miss");
  endtask

  task automatic t_protect();
    sel = 3'd5; allow = 1'b0;
    do_write(16'hA000, 8'hFF, "R4 protected");
    do_write(16'hB2A1, 8'h00, "R4 protected");
    do_read(16'hA000, 1'b1, "R4 keep old");
    do_read(16'hB2A1, 1'b1, "R4 keep old");
    chk("R4 byte unchanged", 32'(stored(16'hA000)), 32'h3C);
    allow = 1'b1;
  endtask

  task automatic t_disable();
    sel = 3'd5;
    drive(16'hA7FE, 1'b1, 1'b0);
    opt = 1'b1; extn = 1'b0;
    #1;
    chk("R6 before sample oe", 32'(doe), 32'd1);
    @(negedge clk); #1;
    chk("R6 after sample oe", 32'(doe), 32'd0);
    chk("R6 cs kept", 32'(row_cs), 32'(row_bit(16'hA7FE)));
    chk("R5 quiet data", 32'(dout), 32'd0);
    extn = 1'b1; #1;
    chk("R6 line released oe", 32'(doe), 32'd1);
    rd = 1'b0; extn = 1'b0;
    do_write(16'hA7FE, 8'h77, "R5 disable vs write");
    extn = 1'b1;
    do_read(16'hA7FE, 1'b1, "R5 write landed");
    extn = 1'b0;
    do_read(16'hB2A1, 1'b0, "R6 disabled read");
    @(negedge clk);
    opt = 1'b0;
    @(negedge clk);
    do_read(16'hB2A1, 1'b1, "R6 line ignored");
    extn = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 1024; j++)
        bank[i][j] = 8'h00;
    t_reset();
    t_window();
    t_rows();
    t_write_read();
    t_protect();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule